// File: doc/BRIEF.md
# Serial ADC Three-Byte Reader

This block is the host side of a serial link to an 8-bit multi-channel sampling converter. Software or a sequencer hands it one request: a channel select, a unipolar/bipolar choice and a single-ended/differential choice. The block then runs one complete reading on a mode-0 SPI bus, where the clock idles low and data is sampled on the rising edge. It pulls chip select low and clocks exactly three bytes in both directions. It then releases chip select and presents the 8-bit conversion code together with a one-cycle valid strobe.

The first byte sent is the control word. Its clock-mode and power bits are always set, so the converter runs its conversion from the serial clock and stays powered up. The byte received during it carries nothing and is thrown away. Two zero bytes follow. The sixteen bits received during them hold the result inside a fixed window: two leading pad bits, eight result bits with the most significant first, and six trailing pad bits.

The serial clock half period is a build-time count of system clocks. The sequencer adds one lead half period before the first edge and one trail half period after the last edge. After chip select rises it also enforces an idle guard of one full serial clock period before another request can be taken.

Top module: `adc_reader`

## Requirements
- R1: Out of reset, chip select is high, the serial clock and MOSI are low, and busy and the valid strobe are low.
- R2: A request is taken only while busy is low. On the clock edge that takes it, the select, polarity and input-mode inputs are captured, chip select falls and busy rises. Chip select is never low while busy is low.
- R3: Each reading has exactly 24 rising serial clock edges while chip select is low, which is three 8-bit transfers. The serial clock is low whenever chip select is high.
- R4: The first 8 bits on MOSI, most significant first, are: 1, sel[2], sel[1], sel[0], uni (1 = unipolar), sgl (1 = single-ended), 1, 1.
- R5: MOSI bits 9 to 24 of the reading are all zero.
- R6: Mode 0. MOSI changes only while the serial clock is low, and MISO is sampled on each rising edge.
- R7: Take the 16 MISO bits sampled on rising edges 9 to 24 as a word whose first sampled bit is bit 15. The result is bits [13:6] of that word. The bits sampled during the first byte, and pad bits [15:14] and [5:0], have no effect on the result.
- R8: The valid strobe lasts one system clock and coincides with the first cycle in which chip select is high again. The result output then holds its value until the next reading ends.
- R9: The serial clock period is 2·HALF_DIV system clocks. The default of 100 gives 500 kHz from a 100 MHz clock, which lies inside the 50 kHz to 500 kHz range.
- R10: Chip select stays low for less than 1 ms per reading. With the default divider this is 49 half periods.
- R11: A request made while busy is ignored. This includes the guard interval after chip select rises, so chip select stays high for at least one full serial clock period between readings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start a reading (taken when idle) |
| req_sel | input | 3 | Channel select code |
| req_uni | input | 1 | 1 = unipolar, 0 = bipolar |
| req_sgl | input | 1 | 1 = single-ended, 0 = differential |
| busy | output | 1 | Reading or guard interval in progress |
| rslt_valid | output | 1 | One-cycle strobe: result ready |
| rslt_data | output | 8 | Conversion code |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to converter |
| spi_miso | input | 1 | Serial data from converter |

## Verification
The hardest case to reach from the ports is a request that arrives after chip select has risen but before the guard period has run out. Here the block looks finished from the outside and must still refuse the request. The bench reaches it in two ways. It pulses a request in the cycle right after the valid strobe and then checks that chip select never falls again. It also holds the request line high without a break across two readings and measures how many system clocks chip select stays high between them. A converter model on MISO puts ones in the discarded first byte and in the pad bits, so a result window placed at the wrong bits shows up as a wrong code.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  // Sequencer phases of one reading.
  typedef enum logic [2:0] {
    RD_IDLE,   // waiting for a request
    RD_LEAD,   // chip select low, first half period before the first rising edge
    RD_XFER,   // 24 serial clock periods
    RD_TRAIL,  // half period after the last falling edge
    RD_GUARD   // chip select high, one full serial clock period
  } rd_state_t;

  // Fixed low bits of the control word: external clock, powered up.
  localparam logic [1:0] CTL_TAIL = 2'b11;

endpackage

// File: rtl/adc_rd_clkdiv.sv
module adc_rd_clkdiv #(
  parameter int unsigned HALF_DIV = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);

  localparam int unsigned CNT_W = $clog2(HALF_DIV + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_DIV - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = run && (cnt_q == CNT_LAST);
    cnt_d = cnt_q;
    if (!run) begin
      cnt_d = '0;
    end else if (tick) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/adc_rd_shift.sv
module adc_rd_shift #(
  parameter int unsigned FRAME_W = 24,
  parameter int unsigned KEEP_W  = 14,
  parameter int unsigned RES_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] load_word,
  input  logic               shift_en,
  input  logic               sample_en,
  input  logic               miso,
  output logic               mosi,
  output logic [RES_W-1:0]   res_bits
);

  localparam int unsigned RES_LSB = KEEP_W - RES_W;

  logic [FRAME_W-1:0] tx_q, tx_d;
  logic [KEEP_W-1:0]  rx_q, rx_d;

  always_comb begin
    tx_d = tx_q;
    if (load) begin
      tx_d = load_word;
    end else if (shift_en) begin
      tx_d = {tx_q[FRAME_W-2:0], 1'b0};
    end
    rx_d = rx_q;
    if (sample_en) begin
      rx_d = {rx_q[KEEP_W-2:0], miso};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      if (load || shift_en) tx_q <= tx_d;
      if (sample_en)        rx_q <= rx_d;
    end
  end

  assign mosi     = tx_q[FRAME_W-1];
  assign res_bits = rx_q[RES_LSB +: RES_W];

endmodule

// File: rtl/adc_reader.sv
module adc_reader #(
  parameter int unsigned HALF_DIV = 100,
  parameter int unsigned SEL_W    = 3,
  parameter int unsigned BYTE_W   = 8,
  parameter int unsigned N_BYTES  = 3,
  parameter int unsigned RES_W    = 8,
  parameter int unsigned PAD_LEAD = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [SEL_W-1:0] req_sel,
  input  logic             req_uni,
  input  logic             req_sgl,
  output logic             busy,
  output logic             rslt_valid,
  output logic [RES_W-1:0] rslt_data,
  output logic             spi_cs_n,
  output logic             spi_sclk,
  output logic             spi_mosi,
  input  logic             spi_miso
);

  import adc_rd_pkg::*;

  localparam int unsigned FRAME_W = BYTE_W * N_BYTES;
  localparam int unsigned RX_W    = BYTE_W * (N_BYTES - 1);
  localparam int unsigned KEEP_W  = RX_W - PAD_LEAD;
  localparam int unsigned BIT_W   = $clog2(FRAME_W);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME_W - 1);

  rd_state_t        state_q, state_d;
  logic             sclk_q, sclk_d;
  logic             cs_n_q, cs_n_d;
  logic             valid_q, valid_d;
  logic [RES_W-1:0] data_q, data_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic             guard_q, guard_d;

  logic               run, tick;
  logic               load, shift_en, sample_en;
  logic [FRAME_W-1:0] ctl_word;
  logic [RES_W-1:0]   res_bits;

  assign run      = (state_q != RD_IDLE);
  assign ctl_word = {1'b1, req_sel, req_uni, req_sgl, CTL_TAIL, {(FRAME_W-BYTE_W){1'b0}}};

  adc_rd_clkdiv #(
    .HALF_DIV (HALF_DIV)
  ) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .tick  (tick)
  );

  adc_rd_shift #(
    .FRAME_W (FRAME_W),
    .KEEP_W  (KEEP_W),
    .RES_W   (RES_W)
  ) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .load_word (ctl_word),
    .shift_en  (shift_en),
    .sample_en (sample_en),
    .miso      (spi_miso),
    .mosi      (spi_mosi),
    .res_bits  (res_bits)
  );

  // Next-state logic.
  always_comb begin
    state_d   = state_q;
    sclk_d    = sclk_q;
    cs_n_d    = cs_n_q;
    valid_d   = 1'b0;
    data_d    = data_q;
    bit_d     = bit_q;
    guard_d   = guard_q;
    load      = 1'b0;
    shift_en  = 1'b0;
    sample_en = 1'b0;
    unique case (state_q)
      RD_IDLE: begin
        if (req_valid) begin
          load    = 1'b1;
          cs_n_d  = 1'b0;
          bit_d   = '0;
          state_d = RD_LEAD;
        end
      end
      RD_LEAD: begin
        if (tick) begin
          sclk_d    = 1'b1;
          sample_en = 1'b1;
          state_d   = RD_XFER;
        end
      end
      RD_XFER: begin
        if (tick) begin
          if (sclk_q) begin
            sclk_d   = 1'b0;
            shift_en = 1'b1;
            if (bit_q == BIT_LAST) begin
              bit_d   = '0;
              state_d = RD_TRAIL;
            end else begin
              bit_d = bit_q + BIT_W'(1);
            end
          end else begin
            sclk_d    = 1'b1;
            sample_en = 1'b1;
          end
        end
      end
      RD_TRAIL: begin
        if (tick) begin
          cs_n_d  = 1'b1;
          valid_d = 1'b1;
          data_d  = res_bits;
          guard_d = 1'b0;
          state_d = RD_GUARD;
        end
      end
      RD_GUARD: begin
        if (tick) begin
          if (guard_q) begin
            guard_d = 1'b0;
            state_d = RD_IDLE;
          end else begin
            guard_d = 1'b1;
          end
        end
      end
      default: state_d = RD_IDLE;
    endcase
  end

  // State registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RD_IDLE;
      sclk_q  <= 1'b0;
      cs_n_q  <= 1'b1;
      valid_q <= 1'b0;
      data_q  <= '0;
      bit_q   <= '0;
      guard_q <= 1'b0;
    end else begin
      state_q <= state_d;
      sclk_q  <= sclk_d;
      cs_n_q  <= cs_n_d;
      valid_q <= valid_d;
      bit_q   <= bit_d;
      guard_q <= guard_d;
      if (valid_d) data_q <= data_d;
    end
  end

  assign busy       = run;
  assign rslt_valid = valid_q;
  assign rslt_data  = data_q;
  assign spi_cs_n   = cs_n_q;
  assign spi_sclk   = sclk_q;

endmodule

// File: rtl/adc_reader_chk.sv
module adc_reader_chk #(
  parameter int unsigned N_EDGES = 24
) (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic busy,
  input logic rslt_valid,
  input logic spi_cs_n,
  input logic spi_sclk,
  input logic spi_mosi
);

  localparam int unsigned EC_W = $clog2(N_EDGES + 1) + 1;

  logic            sclk_prev;
  logic [EC_W-1:0] edge_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev <= 1'b0;
      edge_cnt  <= '0;
    end else begin
      sclk_prev <= spi_sclk;
      if (spi_cs_n) begin
        edge_cnt <= '0;
      end else if (spi_sclk && !sclk_prev) begin
        edge_cnt <= edge_cnt + EC_W'(1);
      end
    end
  end

  AST_SCLK_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk); // R3

  AST_EDGE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |-> (edge_cnt == EC_W'(N_EDGES))); // R3

  AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi)); // R6

  AST_CS_LOW_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_cs_n |-> busy); // R2

  AST_ACCEPT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> ($past(req_valid) && !$past(busy))); // R2

  AST_VALID_AT_CS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    rslt_valid |-> $rose(spi_cs_n)); // R8

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rslt_valid |=> !rslt_valid); // R8

  AST_GUARD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rslt_valid |=> (busy && spi_cs_n)); // R11

endmodule

bind adc_reader adc_reader_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .busy       (busy),
  .rslt_valid (rslt_valid),
  .spi_cs_n   (spi_cs_n),
  .spi_sclk   (spi_sclk),
  .spi_mosi   (spi_mosi)
);

// File: tb/adc_reader_tb.sv
module adc_reader_tb;

  localparam int HALF = 100;

  logic       clk;
  logic       rst_n;
  logic       req_valid;
  logic [2:0] req_sel;
  logic       req_uni;
  logic       req_sgl;
  logic       busy;
  logic       rslt_valid;
  logic [7:0] rslt_data;
  logic       spi_cs_n;
  logic       spi_sclk;
  logic       spi_mosi;
  logic       spi_miso;

  adc_reader #(.HALF_DIV(HALF)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_sel    (req_sel),
    .req_uni    (req_uni),
    .req_sgl    (req_sgl),
    .busy       (busy),
    .rslt_valid (rslt_valid),
    .rslt_data  (rslt_data),
    .spi_cs_n   (spi_cs_n),
    .spi_sclk   (spi_sclk),
    .spi_mosi   (spi_mosi),
    .spi_miso   (spi_miso)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int vec = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;

  // Converter model and bus monitors.
  logic [23:0] dev_frame = '0;
  int          fall_idx  = 0;
  logic [23:0] mosi_cap  = '0;
  int          rise_cnt  = 0;
  int          last_rise = 0;
  int          per_min   = 0;
  int          per_max   = 0;
  int          cs_low    = 0;
  int          cs_falls  = 0;

  assign spi_miso = (!spi_cs_n && fall_idx < 24) ? dev_frame[5'(23 - fall_idx)] : 1'b0;

  always @(negedge spi_sclk) if (!spi_cs_n) fall_idx++;
  always @(negedge spi_cs_n) cs_falls++;
  always @(negedge clk) begin
    cyc++;
    if (!spi_cs_n) cs_low++;
  end
  always @(posedge spi_sclk) begin
    if (!spi_cs_n) begin
      mosi_cap = {mosi_cap[22:0], spi_mosi};
      if (rise_cnt > 0) begin
        if (cyc - last_rise < per_min) per_min = cyc - last_rise;
        if (cyc - last_rise > per_max) per_max = cyc - last_rise;
      end
      last_rise = cyc;
      rise_cnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clear_mon();
    fall_idx = 0;
    mosi_cap = '0;
    rise_cnt = 0;
    per_min  = 1000000;
    per_max  = 0;
    cs_low   = 0;
  endtask

  function automatic logic [7:0] ctl(input logic [2:0] s, input logic u, input logic g);
    return {1'b1, s, u, g, 2'b11};
  endfunction

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
  endtask

  // Issue a one-cycle request while idle; checks acceptance (R2).
  task automatic start_read(input logic [2:0] s, input logic u, input logic g,
                            input logic [23:0] frame);
    dev_frame = frame;
    clear_mon();
    @(negedge clk);
    req_sel = s; req_uni = u; req_sgl = g; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    req_sel = ~s; req_uni = ~u; req_sgl = ~g;
    chk(busy == 1'b1, "R2", "busy after accept", int'(busy), 1);
    chk(spi_cs_n == 1'b0, "R2", "cs low after accept", int'(spi_cs_n), 0);
  endtask

  // Wait for the strobe and check the finished reading.
  task automatic finish_read(input logic [7:0] exp_ctl, input logic [7:0] exp_res);
    int t = 0;
    while (!rslt_valid && t < 20000) begin
      @(negedge clk);
      t++;
    end
    chk(rslt_valid == 1'b1, "R8", "strobe seen", int'(rslt_valid), 1);
    chk(spi_cs_n == 1'b1, "R8", "cs high with strobe", int'(spi_cs_n), 1);
    chk(rslt_data == exp_res, "R7", "result window", int'(rslt_data), int'(exp_res));
    chk(rise_cnt == 24, "R3", "rising edges", rise_cnt, 24);
    chk(mosi_cap[23:16] == exp_ctl, "R4", "control byte", int'(mosi_cap[23:16]), int'(exp_ctl));
    chk(mosi_cap[15:0] == 16'h0, "R5", "pad bytes", int'(mosi_cap[15:0]), 0);
    chk(per_min == 2*HALF && per_max == 2*HALF, "R9", "sclk period", per_max, 2*HALF);
    chk(per_max >= 200 && per_min <= 2000 && per_min >= 200, "R9", "rate 50k-500k", per_min, 200);
    chk(cs_low < 100000 && cs_low > 48*HALF, "R10", "cs low cycles", cs_low, 49*HALF);
    @(negedge clk);
    chk(rslt_valid == 1'b0, "R8", "strobe width", int'(rslt_valid), 0);
    chk(rslt_data == exp_res, "R8", "result held", int'(rslt_data), int'(exp_res));
  endtask

  task automatic wait_idle();
    int t = 0;
    while (busy && t < 5000) begin
      @(negedge clk);
      t++;
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; req_valid = 1'b0; req_sel = '0; req_uni = 1'b0; req_sgl = 1'b0;
    repeat (3) @(negedge clk);
    chk(spi_cs_n == 1'b1, "R1", "cs in reset", int'(spi_cs_n), 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(spi_cs_n == 1'b1 && spi_sclk == 1'b0 && spi_mosi == 1'b0, "R1", "bus idle",
        int'({spi_cs_n, spi_sclk, spi_mosi}), 4);
    chk(busy == 1'b0 && rslt_valid == 1'b0, "R1", "flags idle", int'({busy, rslt_valid}), 0);
  endtask

  // Ones in the dropped byte and in the pad bits must not leak (R7).
  task automatic t_window_noise();
    start_read(3'd0, 1'b1, 1'b1, {8'hFF, 2'b11, 8'hA5, 6'h3F});
    finish_read(ctl(3'd0, 1'b1, 1'b1), 8'hA5);
    wait_idle();
  endtask

  task automatic t_code_zero();
    start_read(3'd5, 1'b0, 1'b1, {8'h5A, 2'b11, 8'h00, 6'h3F});
    finish_read(ctl(3'd5, 1'b0, 1'b1), 8'h00);
    wait_idle();
  endtask

  task automatic t_code_full();
    start_read(3'd3, 1'b1, 1'b0, {8'h00, 2'b00, 8'hFF, 6'h00});
    finish_read(ctl(3'd3, 1'b1, 1'b0), 8'hFF);
    wait_idle();
  endtask

  // Requests mid-reading and inside the guard interval are dropped (R11).
  task automatic t_ignore_busy();
    int f0;
    start_read(3'd2, 1'b1, 1'b0, {8'h00, 2'b00, 8'h96, 6'h00});
    repeat (1000) @(negedge clk);
    req_sel = 3'd5; req_uni = 1'b0; req_sgl = 1'b1; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    finish_read(ctl(3'd2, 1'b1, 1'b0), 8'h96);
    f0 = cs_falls;
    req_sel = 3'd6; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3*HALF) @(negedge clk);
    chk(cs_falls == f0, "R11", "guard request dropped", cs_falls, f0);
    chk(busy == 1'b0 && spi_cs_n == 1'b1, "R11", "idle after guard",
        int'({busy, spi_cs_n}), 1);
  endtask

  // Request held high: the gap between readings is at least one period (R11).
  task automatic t_back_to_back();
    int g = 1;
    dev_frame = {8'h00, 2'b00, 8'h3C, 6'h00};
    clear_mon();
    @(negedge clk);
    req_sel = 3'd7; req_uni = 1'b0; req_sgl = 1'b0; req_valid = 1'b1;
    finish_read(ctl(3'd7, 1'b0, 1'b0), 8'h3C);
    dev_frame = {8'hC3, 2'b00, 8'h81, 6'h00};
    while (spi_cs_n && g < 5000) begin
      @(negedge clk);
      g++;
    end
    req_valid = 1'b0;
    clear_mon();
    chk(g >= 2*HALF && g < 5000, "R11", "cs high gap", g, 2*HALF);
    finish_read(ctl(3'd7, 1'b0, 1'b0), 8'h81);
    wait_idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      vec++;
      bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
    end
  end

  initial begin
    t_reset();
    t_window_noise();
    t_code_zero();
    t_code_full();
    t_ignore_busy();
    t_back_to_back();
    done = 1;
    report();
    $finish;
  end

endmodule